// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Result Pair

This block performs 32-bit integer multiplication and division one bit per clock, independently of the instruction pipeline that launches it. It writes its results into a dedicated pair of result registers, HI and LO. A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. The pipeline launches an operation with a one-cycle start strobe and continues with other work. It later reads HI or LO through a read request, which the block holds off with a stall request until the running operation has produced its result.

Software can also load HI or LO directly with an explicit write, which is how the pair is restored after an exception. A new start, or an explicit write, that arrives while an operation is running abandons that operation. A read that arrives in the very cycle the result is being committed receives the new value at once, without a stall.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, busy_o and stall_o are low, and both HI and LO read as zero.
- R2: Operation code bit 1 selects divide (1) or multiply (0). Bit 0 selects signed (1) or unsigned (0) operands. With code 2'b00, HI receives the upper 32 bits and LO the lower 32 bits of the unsigned 64-bit product.
- R3: With code 2'b01, HI:LO receives the two's-complement 64-bit product of the signed operands.
- R4: With codes 2'b10 (unsigned) and 2'b11 (signed), LO receives the quotient and HI the remainder. Signed division truncates toward zero, and the remainder takes the sign of the dividend. The quotient of -2^31 by -1 wraps to 0x80000000.
- R5: A divide by zero takes the normal time and leaves LO = 0xFFFFFFFF and HI = the dividend as given.
- R6: busy_o rises in the cycle after a start is sampled and stays high for 33 cycles. The result is committed on the 33rd clock edge after the start edge.
- R7: A read request (rd_hi_i or rd_lo_i) while busy is high raises stall_o in every cycle except the commit cycle. When both requests are high, HI is returned.
- R8: A read in the commit cycle is not stalled and returns the result being committed.
- R9: An explicit write loads wr_data_i into HI (wr_hi_i) or LO (wr_lo_i) on the next edge. The other register is left unchanged.
- R10: A start while busy abandons the running operation. The new operation's result is delivered with full latency counted from the new start.
- R11: An explicit write while busy abandons the running operation. busy_o is low after that edge, the written register holds the data, and the other register keeps its earlier value.
- R12: stall_o is never high without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation this cycle |
| op_i | input | 2 | Operation code: bit 1 divide, bit 0 signed |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| wr_hi_i | input | 1 | Load wr_data_i into HI |
| wr_lo_i | input | 1 | Load wr_data_i into LO |
| wr_data_i | input | 32 | Data for explicit writes |
| rd_hi_i | input | 1 | Read request for HI |
| rd_lo_i | input | 1 | Read request for LO |
| busy_o | output | 1 | Operation in flight |
| stall_o | output | 1 | Read must be held off this cycle |
| rd_data_o | output | 32 | Read data, valid when a read is requested and stall_o is low |

## Verification
An operation sampled on clock edge E0 iterates on edges E1 through E32 and commits on E33. A read raised right after E0 therefore sees exactly 32 stalled cycles, and it is accepted in the cycle before E33 with the forwarded value. The read for the other half is accepted in the cycle after E33, from the register. The driver counts the stalled cycles against that figure and queues the expected value before it raises the request. The monitor compares the value on the falling edge of every cycle in which a request is high and stall_o is low. For the abort cases, the count restarts at the new start, and busy_o is checked low one edge after the explicit write.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  // bit 1: divide, bit 0: signed operands
  typedef enum logic [1:0] {
    MDU_MULU = 2'b00,
    MDU_MULS = 2'b01,
    MDU_DIVU = 2'b10,
    MDU_DIVS = 2'b11
  } mdu_op_e;
endpackage

// File: rtl/mdu_seq.sv
// Iteration sequencer: WIDTH step cycles, then one commit cycle.
module mdu_seq #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic step_o,
  output logic commit_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      cnt_en = 1'b1;
    end else if (abort_i) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      if (at_last) begin
        busy_n = 1'b0;
      end else begin
        cnt_n  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign busy_o   = busy_q;
  assign step_o   = busy_q & ~at_last & ~start_i & ~abort_i;
  assign commit_o = busy_q &  at_last & ~start_i & ~abort_i;
endmodule

// File: rtl/mdu_mul_iter.sv
// Shift-add multiplier on magnitudes, one multiplier bit per step.
module mdu_mul_iter #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q, prod_n;
  logic [WIDTH:0]   sum;
  logic             prod_en;

  always_comb begin
    sum     = {1'b0, prod_q[PW-1:WIDTH]}
            + {1'b0, (prod_q[0] ? mcand_q : {WIDTH{1'b0}})};
    prod_en = load_i | step_i;
    if (load_i) prod_n = {{WIDTH{1'b0}}, mplier_i};
    else        prod_n = {sum, prod_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else begin
      if (load_i)  mcand_q <= mcand_i;
      if (prod_en) prod_q  <= prod_n;
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/mdu_div_iter.sv
// Restoring divider on magnitudes, one quotient bit per step.
module mdu_div_iter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  logic [WIDTH-1:0] dvs_q;
  logic [WIDTH-1:0] quo_q, quo_n;
  logic [WIDTH-1:0] rem_q, rem_n;
  logic [WIDTH:0]   shifted;
  logic [WIDTH-1:0] trial;
  logic             fits;
  logic             upd_en;

  always_comb begin
    shifted = {rem_q, quo_q[WIDTH-1]};
    fits    = (shifted >= {1'b0, dvs_q});
    trial   = shifted[WIDTH-1:0] - dvs_q;
    upd_en  = load_i | step_i;
    if (load_i) begin
      rem_n = '0;
      quo_n = dividend_i;
    end else begin
      rem_n = fits ? trial : shifted[WIDTH-1:0];
      quo_n = {quo_q[WIDTH-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
    end else begin
      if (load_i) dvs_q <= divisor_i;
      if (upd_en) begin
        quo_q <= quo_n;
        rem_q <= rem_n;
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/mdu_hilo.sv
// Result register pair with commit and explicit load paths.
module mdu_hilo #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [WIDTH-1:0] res_hi_i,
  input  logic [WIDTH-1:0] res_lo_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  logic [WIDTH-1:0] hi_q, hi_n, lo_q, lo_n;
  logic             hi_en, lo_en;

  always_comb begin
    hi_en = commit_i | wr_hi_i;
    lo_en = commit_i | wr_lo_i;
    hi_n  = wr_hi_i ? wr_data_i : res_hi_i;
    lo_n  = wr_lo_i ? wr_data_i : res_lo_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_n;
      if (lo_en) lo_q <= lo_n;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  output logic             busy_o,
  output logic             stall_o,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int PW = 2 * WIDTH;

  logic             step, commit, abort;
  logic             a_neg, b_neg, sgn;
  logic [WIDTH-1:0] a_mag, b_mag;
  logic [PW-1:0]    prod_mag, prod_fix;
  logic [WIDTH-1:0] quo_mag, rem_mag;
  logic [WIDTH-1:0] res_hi, res_lo;
  logic [WIDTH-1:0] hi_val, lo_val;
  logic             rd_any;

  // operation context captured at start
  logic             is_div_q, neg_res_q, neg_rem_q, dz_q;
  logic [WIDTH-1:0] dvd_q;
  logic             is_div_n, neg_res_n, neg_rem_n, dz_n;

  assign abort = wr_hi_i | wr_lo_i;

  always_comb begin
    sgn       = op_i[0];
    a_neg     = sgn & a_i[WIDTH-1];
    b_neg     = sgn & b_i[WIDTH-1];
    a_mag     = a_neg ? (~a_i + 1'b1) : a_i;
    b_mag     = b_neg ? (~b_i + 1'b1) : b_i;
    is_div_n  = op_i[1];
    neg_res_n = a_neg ^ b_neg;
    neg_rem_n = a_neg;
    dz_n      = (b_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_div_q  <= 1'b0;
      neg_res_q <= 1'b0;
      neg_rem_q <= 1'b0;
      dz_q      <= 1'b0;
      dvd_q     <= '0;
    end else if (start_i) begin
      is_div_q  <= is_div_n;
      neg_res_q <= neg_res_n;
      neg_rem_q <= neg_rem_n;
      dz_q      <= dz_n;
      dvd_q     <= a_i;
    end
  end

  mdu_seq #(.WIDTH(WIDTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .abort_i  (abort),
    .busy_o   (busy_o),
    .step_o   (step),
    .commit_o (commit)
  );

  mdu_mul_iter #(.WIDTH(WIDTH)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_i),
    .step_i   (step),
    .mcand_i  (a_mag),
    .mplier_i (b_mag),
    .prod_o   (prod_mag)
  );

  mdu_div_iter #(.WIDTH(WIDTH)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .step_i     (step),
    .dividend_i (a_mag),
    .divisor_i  (b_mag),
    .quo_o      (quo_mag),
    .rem_o      (rem_mag)
  );

  // sign restoration and divide-by-zero override
  always_comb begin
    prod_fix = neg_res_q ? (~prod_mag + 1'b1) : prod_mag;
    if (!is_div_q) begin
      res_hi = prod_fix[PW-1:WIDTH];
      res_lo = prod_fix[WIDTH-1:0];
    end else if (dz_q) begin
      res_hi = dvd_q;
      res_lo = '1;
    end else begin
      res_hi = neg_rem_q ? (~rem_mag + 1'b1) : rem_mag;
      res_lo = neg_res_q ? (~quo_mag + 1'b1) : quo_mag;
    end
  end

  mdu_hilo #(.WIDTH(WIDTH)) u_hilo (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .res_hi_i  (res_hi),
    .res_lo_i  (res_lo),
    .wr_hi_i   (wr_hi_i),
    .wr_lo_i   (wr_lo_i),
    .wr_data_i (wr_data_i),
    .hi_o      (hi_val),
    .lo_o      (lo_val)
  );

  // read port: interlock against the running operation, forward on commit
  always_comb begin
    rd_any  = rd_hi_i | rd_lo_i;
    stall_o = rd_any & busy_o & ~commit;
    if (commit) rd_data_o = rd_hi_i ? res_hi : res_lo;
    else        rd_data_o = rd_hi_i ? hi_val : lo_val;
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             wr_hi_i,
  input logic             wr_lo_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             rd_hi_i,
  input logic             rd_lo_i,
  input logic             busy_o,
  input logic             stall_o,
  input logic [WIDTH-1:0] hi_val,
  input logic [WIDTH-1:0] lo_val
);
  a_r12_stall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (rd_hi_i || rd_lo_i));

  a_r7_stall_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> busy_o);

  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  a_r11_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_hi_i || wr_lo_i) && !start_i) |=> !busy_o);

  a_r9_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_i |=> (hi_val == $past(wr_data_i)));

  a_r9_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> (lo_val == $past(wr_data_i)));

  a_r9_idle_pair_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !wr_hi_i && !wr_lo_i) |=> ($stable(hi_val) && $stable(lo_val)));
endmodule

bind muldiv_hilo mdu_checker #(.WIDTH(WIDTH)) u_mdu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .wr_hi_i   (wr_hi_i),
  .wr_lo_i   (wr_lo_i),
  .wr_data_i (wr_data_i),
  .rd_hi_i   (rd_hi_i),
  .rd_lo_i   (rd_lo_i),
  .busy_o    (busy_o),
  .stall_o   (stall_o),
  .hi_val    (hi_val),
  .lo_val    (lo_val)
);

// File: tb/test_muldiv_hilo.sv
module test_muldiv_hilo;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, wr_hi_i, wr_lo_i, rd_hi_i, rd_lo_i;
  logic [1:0]   op_i;
  logic [W-1:0] a_i, b_i, wr_data_i;
  logic         busy_o, stall_o;
  logic [W-1:0] rd_data_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] cur_hi, cur_lo;

  always #4 clk = ~clk;

  muldiv_hilo #(.WIDTH(W)) i_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .wr_data_i(wr_data_i), .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i),
    .busy_o(busy_o), .stall_o(stall_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every accepted read consumes one expected item
  always @(negedge clk) begin
    if (rst_n && (rd_hi_i || rd_lo_i) && !stall_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected read", rd_data_o, '0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data_o == e, t, rd_data_o, e);
      end
    end
  end

  // model of the required arithmetic
  task automatic model(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b,
                       output logic [W-1:0] hi, output logic [W-1:0] lo);
    longint sa, sb, sq, sr;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (!op[1]) begin
      if (op[0]) p = 64'(sa * sb);
      else       p = {32'b0, a} * {32'b0, b};
      hi = p[63:32];
      lo = p[31:0];
    end else if (b == '0) begin
      hi = a;
      lo = '1;
    end else if (op[0]) begin
      sq = sa / sb;
      sr = sa % sb;
      hi = sr[31:0];
      lo = sq[31:0];
    end else begin
      hi = a % b;
      lo = a / b;
    end
  endtask

  // all driver tasks start and end just after a rising edge
  task automatic launch(input logic [1:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  // sel: 0 HI, 1 LO, 2 both; lat >= 0 checks the count of stalled cycles
  task automatic read_reg(input int sel, input logic [W-1:0] exp,
                          input string tag, input int lat);
    int n;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_hi_i = (sel != 1);
    rd_lo_i = (sel != 0);
    n = 0;
    forever begin
      @(negedge clk);
      if (stall_o) n++;
      else break;
    end
    @(posedge clk); #1;
    rd_hi_i = 1'b0;
    rd_lo_i = 1'b0;
    if (lat >= 0) chk(n == lat, {tag, " R6 stall cycles"}, n, lat);
  endtask

  task automatic run(input logic [1:0] op, input logic [W-1:0] a,
                     input logic [W-1:0] b, input string tag);
    logic [W-1:0] eh, el;
    model(op, a, b, eh, el);
    launch(op, a, b);
    read_reg(0, eh, {tag, " HI forwarded R8"}, W);
    read_reg(1, el, {tag, " LO"}, -1);
    cur_hi = eh;
    cur_lo = el;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    logic [W-1:0] eh, el;
    rst_n = 1'b0;
    start_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    wr_hi_i = 1'b0; wr_lo_i = 1'b0; wr_data_i = '0;
    rd_hi_i = 1'b0; rd_lo_i = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(busy_o == 1'b0, "R1 busy after reset", W'(busy_o), 0);
    chk(stall_o == 1'b0, "R1 stall after reset", W'(stall_o), 0);
    read_reg(0, '0, "R1 HI after reset", 0);
    read_reg(1, '0, "R1 LO after reset", 0);

    // R2 unsigned multiply
    run(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mulu max*max");
    run(2'b00, 32'd12345, 32'd6789, "R2 mulu small");
    // R3 signed multiply
    run(2'b01, -32'sd3, 32'sd7, "R3 muls -3*7");
    run(2'b01, 32'h8000_0000, 32'h8000_0000, "R3 muls min*min");
    run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 muls -1*-1");
    // R4 division
    run(2'b10, 32'd100, 32'd7, "R4 divu 100/7");
    run(2'b10, 32'hFFFF_FFFF, 32'd16, "R4 divu max/16");
    run(2'b11, -32'sd7, 32'sd2, "R4 divs -7/2");
    run(2'b11, 32'sd7, -32'sd2, "R4 divs 7/-2");
    run(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, "R4 divs min/-1");
    // R5 divide by zero
    run(2'b11, -32'sd5, 32'd0, "R5 divs by zero");
    run(2'b10, 32'h1234_5678, 32'd0, "R5 divu by zero");

    // R12: busy without a read request does not stall; R7 both requests give HI
    model(2'b00, 32'd3, 32'd5, eh, el);
    launch(2'b00, 32'd3, 32'd5);
    @(negedge clk);
    chk(busy_o && !stall_o, "R12 no stall without read", W'(stall_o), 0);
    @(posedge clk); #1;
    read_reg(2, eh, "R7 both requests return HI", W - 1);
    read_reg(1, el, "R7 LO after 3*5", 0);
    cur_hi = eh; cur_lo = el;

    // R9 explicit write to HI leaves LO
    wr_hi_i = 1'b1; wr_data_i = 32'hA5A5_5A5A;
    @(posedge clk); #1;
    wr_hi_i = 1'b0;
    read_reg(0, 32'hA5A5_5A5A, "R9 HI loaded", 0);
    read_reg(1, cur_lo, "R9 LO unchanged", 0);
    wr_lo_i = 1'b1; wr_data_i = 32'h0F0F_1234;
    @(posedge clk); #1;
    wr_lo_i = 1'b0;
    read_reg(1, 32'h0F0F_1234, "R9 LO loaded", 0);
    read_reg(0, 32'hA5A5_5A5A, "R9 HI unchanged", 0);
    cur_hi = 32'hA5A5_5A5A; cur_lo = 32'h0F0F_1234;

    // R10 restart while busy
    launch(2'b00, 32'hDEAD_BEEF, 32'h1234_5678);
    repeat (9) begin @(posedge clk); #1; end
    model(2'b11, -32'sd1000, 32'sd33, eh, el);
    launch(2'b11, -32'sd1000, 32'sd33);
    read_reg(0, eh, "R10 restarted HI", W);
    read_reg(1, el, "R10 restarted LO", -1);
    cur_hi = eh; cur_lo = el;

    // R11 explicit write aborts an operation in flight
    launch(2'b01, 32'h7777_7777, 32'h0000_0101);
    repeat (5) begin @(posedge clk); #1; end
    wr_lo_i = 1'b1; wr_data_i = 32'hCAFE_0001;
    @(posedge clk); #1;
    wr_lo_i = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R11 busy low after write", W'(busy_o), 0);
    @(posedge clk); #1;
    read_reg(1, 32'hCAFE_0001, "R11 LO written", 0);
    read_reg(0, cur_hi, "R11 HI kept", 0);
    repeat (40) begin @(posedge clk); #1; end
    read_reg(0, cur_hi, "R11 HI not overwritten later", 0);

    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule